// File: doc/BRIEF.md
# Nested-Priority Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output for a processor. It records a pending request on each rising edge of a request line. It blocks the lines that software has masked, and it also tracks which levels are being serviced. A handler that is running therefore holds off every request of equal or lower priority. A higher-priority request still gets through, so handlers can nest.

When the processor acknowledges, the controller picks the winning level and moves it from pending to in service. One cycle later it presents a vector built from a programmable base and the level number. Software ends service in one of three ways:
- an end-of-interrupt command that names a level;
- a command that does not name a level and so retires the most urgent in-service level;
- automatic retirement at acknowledge time.

Priority is either fixed or rotating. In rotating mode, the level that was just retired drops to the bottom of the order.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After synchronous reset the controller is in this state: int_out low, vec_out zero, nothing pending or in service, mask register all zeros, vector base zero, fixed priority and manual end-of-interrupt.
- R2: A rising edge on irq_in[i] sets pending bit i, and that bit stays set until level i is acknowledged. A line held high after its acknowledge does not create a second request.
- R3: The mask register is written at address 0, and a 1 in bit i blocks level i. A pending request that is masked does not raise int_out. Clearing the mask bit later raises int_out, because the request is still held.
- R4: Under fixed priority, level 0 ranks highest and level 7 ranks lowest. An acknowledge serves the highest-ranked pending level that is not masked.
- R5: An acknowledge is int_ack high at a clock edge while int_out is high. In the cycle after it, vec_out equals {base[4:0], level[2:0]}, where the base is written at address 1 from wdata[4:0]. An acknowledge while int_out is low changes nothing, and vec_out keeps its value.
- R6: While a level is in service, int_out is raised only by an unmasked pending level that ranks strictly higher than every in-service level.
- R7: A write to address 3 with wdata[3]=1 is a specific end-of-interrupt. It clears the in-service bit named by wdata[2:0].
- R8: A write to address 3 with wdata[3]=0 is a non-specific end-of-interrupt. It clears the highest-ranked in-service bit.
- R9: The mode register is at address 2. With automatic end-of-interrupt selected (wdata[1]=1), an acknowledge does not set an in-service bit, so lower-ranked requests can be served at once.
- R10: With rotating priority selected (mode wdata[0]=1), each level that an end-of-interrupt clears becomes the lowest rank, and the next level number up (modulo 8) becomes the highest. This applies to specific, non-specific and automatic retirement alike. Under fixed priority the order is always 0..7, even after a period of rotation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Request lines; a rising edge requests service |
| int_ack | input | 1 | Acknowledge from the processor |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration target: 0 mask, 1 base, 2 mode, 3 end-of-interrupt |
| cfg_wdata | input | 8 | Configuration write data |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last acknowledged level |

## Verification
The hardest cases to reach are states that several outstanding levels produce together: a stack of nested in-service bits combined with a moved rotation pointer. Only that combination shows which bit a non-specific end-of-interrupt really retires. The stimulus builds such stacks step by step. It acknowledges a low-ranked level, pulses a higher one, and acknowledges again. It then re-raises a level that a wrong clearing choice would leave blocked. Rotation is driven through a known chain of retirements, so that the order of later acknowledges reveals where the pointer sits.

// File: rtl/nic_pkg.sv
// Package: shared widths, configuration targets and end-of-interrupt command
// type for the nested-priority interrupt controller.
// Assumes the number of lines is a power of two.
package nic_pkg;
    localparam int NIC_LINES  = 8;
    localparam int NIC_LVL_W  = $clog2(NIC_LINES);
    localparam int NIC_BASE_W = 5;
    localparam int NIC_DATA_W = 8;
    localparam int NIC_ADDR_W = 2;
    localparam int NIC_VEC_W  = NIC_BASE_W + NIC_LVL_W;

    typedef enum logic [NIC_ADDR_W-1:0] {
        CFG_MASK = 2'd0,
        CFG_BASE = 2'd1,
        CFG_MODE = 2'd2,
        CFG_EOI  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic                 fire;
        logic                 spec;
        logic [NIC_LVL_W-1:0] lvl;
    } eoi_cmd_t;
endpackage

// File: rtl/nic_prio_pick.sv
// Module: rotating priority picker.
// Finds the highest-ranked set bit of req. The rank starts just above
// level low_lvl and wraps, so low_lvl itself is the lowest rank.
// Assumes N is a power of two and W = log2(N).
module nic_prio_pick #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] low_lvl,
    output logic         found,
    output logic [W-1:0] top_lvl
);
    // Scan from the lowest rank to the highest, so the last hit is the winner.
    always_comb begin
        found   = |req;
        top_lvl = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[(int'(low_lvl) + 1 + k) % N]) begin
                top_lvl = W'((int'(low_lvl) + 1 + k) % N);
            end
        end
    end
endmodule

// File: rtl/nic_cfg.sv
// Module: configuration write port of the interrupt controller.
// Holds the mask, the vector base and the mode bits, and decodes
// end-of-interrupt writes into a single-cycle command.
// Assumes single-cycle write strobes; there is no read path.
module nic_cfg
    import nic_pkg::*;
#(
    parameter int N      = NIC_LINES,
    parameter int LW     = $clog2(N),
    parameter int BASE_W = NIC_BASE_W,
    parameter int DW     = NIC_DATA_W,
    parameter int AW     = NIC_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [N-1:0]      mask,
    output logic [BASE_W-1:0] base,
    output logic              rotate,
    output logic              auto_eoi,
    output eoi_cmd_t          eoi
);
    localparam int SPEC_BIT = LW;

    // Register writes to the mask, base and mode targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask     <= '0;
            base     <= '0;
            rotate   <= 1'b0;
            auto_eoi <= 1'b0;
        end else if (we) begin
            case (cfg_sel_e'(addr))
                CFG_MASK: mask <= wdata[N-1:0];
                CFG_BASE: base <= wdata[BASE_W-1:0];
                CFG_MODE: begin
                    rotate   <= wdata[0];
                    auto_eoi <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    // Decode an end-of-interrupt write into a one-cycle command.
    always_comb begin
        eoi.fire = we && (cfg_sel_e'(addr) == CFG_EOI);
        eoi.spec = wdata[SPEC_BIT];
        eoi.lvl  = wdata[LW-1:0];
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
// Module: nested-priority interrupt controller (top).
// Captures rising request edges. It holds pending, in-service and
// rotation-pointer state, raises int_out for the winning unmasked request,
// and serves acknowledges and end-of-interrupt commands.
// Assumes int_ack is synchronous to clk. Acknowledge and configuration
// writes may arrive in the same cycle.
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int N      = NIC_LINES,
    parameter int BASE_W = NIC_BASE_W,
    parameter int DW     = NIC_DATA_W,
    parameter int AW     = NIC_ADDR_W,
    parameter int LW     = $clog2(N),
    parameter int VW     = BASE_W + LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          int_ack,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic          int_out,
    output logic [VW-1:0] vec_out
);
    localparam logic [LW-1:0] LAST_LVL = LW'(N - 1);
    localparam logic [N-1:0]  ONE_BIT  = N'(1);

    logic [N-1:0]      irq_q, pend, isr, mask;
    logic [N-1:0]      rise, merged, take_oh, clr_oh, set_oh;
    logic [BASE_W-1:0] base;
    logic              rotate, auto_eoi;
    eoi_cmd_t          eoi;
    logic [LW-1:0]     ptr, low_eff, m_top, i_top;
    logic              m_found, i_found, take;
    logic              rot_hit;
    logic [LW-1:0]     rot_lvl;

    nic_cfg #(.N(N), .LW(LW), .BASE_W(BASE_W), .DW(DW), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .mask(mask), .base(base), .rotate(rotate),
        .auto_eoi(auto_eoi), .eoi(eoi)
    );

    // Fixed mode always ranks from the last level, whatever the pointer holds.
    always_comb low_eff = rotate ? ptr : LAST_LVL;

    // Pending requests and in-service levels compete in one ranking.
    always_comb merged = (pend & ~mask) | isr;

    nic_prio_pick #(.N(N), .W(LW)) u_pick_all (
        .req(merged), .low_lvl(low_eff), .found(m_found), .top_lvl(m_top)
    );

    nic_prio_pick #(.N(N), .W(LW)) u_pick_isr (
        .req(isr), .low_lvl(low_eff), .found(i_found), .top_lvl(i_top)
    );

    // Raise the output only if the top of the ranking is a request, not a level in service.
    always_comb int_out = m_found && !isr[m_top];

    // Work out the set, clear and rotate effects for this cycle.
    always_comb begin
        rise    = irq_in & ~irq_q;
        take    = int_ack && int_out;
        take_oh = take ? (ONE_BIT << m_top) : '0;
        set_oh  = auto_eoi ? '0 : take_oh;
        clr_oh  = '0;
        rot_hit = 1'b0;
        rot_lvl = ptr;
        if (take && auto_eoi) begin
            rot_hit = 1'b1;
            rot_lvl = m_top;
        end
        if (eoi.fire) begin
            if (eoi.spec) begin
                clr_oh = ONE_BIT << eoi.lvl;
                if (isr[eoi.lvl]) begin
                    rot_hit = 1'b1;
                    rot_lvl = eoi.lvl;
                end
            end else if (i_found) begin
                clr_oh  = ONE_BIT << i_top;
                rot_hit = 1'b1;
                rot_lvl = i_top;
            end
        end
    end

    // Edge capture plus the pending and in-service registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            pend  <= '0;
            isr   <= '0;
        end else begin
            irq_q <= irq_in;
            pend  <= (pend & ~take_oh) | rise;
            isr   <= (isr & ~clr_oh) | set_oh;
        end
    end

    // Rotation pointer: parked on the last level in fixed mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !rotate) begin
            ptr <= LAST_LVL;
        end else if (rot_hit) begin
            ptr <= rot_lvl;
        end
    end

    // Vector register, loaded on every accepted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out <= '0;
        end else if (take) begin
            vec_out <= {base, m_top};
        end
    end

    AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> |(pend & ~mask)) else $error("int_out without request"); // R3

    AST_ACK_VEC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out) |=> (vec_out[LW-1:0] == $past(m_top))) else $error("vector level"); // R5

    AST_ACK_NO_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_out) |=> $stable(vec_out)) else $error("ignored ack moved vector"); // R5

    AST_ACK_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out && !auto_eoi) |=> isr[$past(m_top)]) else $error("ack not in service"); // R6

    AST_SPEC_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi.fire && eoi.spec && !(int_ack && int_out && !auto_eoi)) |=> !isr[$past(eoi.lvl)])
        else $error("specific eoi left bit"); // R7

    AST_AUTO_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out && auto_eoi && !eoi.fire) |=> (isr == $past(isr)))
        else $error("auto eoi set in-service bit"); // R9

    AST_FIXED_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        !rotate |=> (ptr == LAST_LVL)) else $error("pointer moved in fixed mode"); // R10
endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       int_ack = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       int_out;
    logic [7:0] vec_out;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q[$];
    logic [7:0] last_vec = 8'h00;
    logic       ack_d = 1'b0;
    logic [7:0] exp_v;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    nest_irq_ctrl i_nest_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_ack(int_ack),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .int_out(int_out), .vec_out(vec_out)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(logic [7:0] m);
        irq_in = irq_in | m;
        @(negedge clk);
        irq_in = irq_in & ~m;
    endtask

    // Driver: push the expected vector, then acknowledge for one cycle.
    task automatic ack(logic [7:0] e);
        exp_q.push_back(e);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic eoi_s(int l); wr(2'd3, 8'h08 | 8'(l)); endtask
    task automatic eoi_ns(); wr(2'd3, 8'h00); endtask

    // Monitor: after each acknowledge edge, compare vec_out with the queue head.
    always @(posedge clk) ack_d <= int_ack;
    always @(negedge clk) begin
        if (ack_d) begin
            if (exp_q.size() == 0) begin
                check("R5 queue", 1, 0);
            end else begin
                exp_v = exp_q.pop_front();
                check("R5 vector", int'(vec_out), int'(exp_v));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 int_out", int'(int_out), 0);
        check("R1 vec_out", int'(vec_out), 0);
        wr(2'd1, 8'h15); // base 0x15 -> vectors 0xA8 + level

        // R2 R4 R6: two requests, then nesting
        pulse(8'h24);
        check("R2 int_out", int'(int_out), 1);
        ack(8'hAA);
        check("R6 lower blocked", int'(int_out), 0);
        pulse(8'h02);
        check("R6 higher passes", int'(int_out), 1);
        ack(8'hA9);
        check("R6 both blocked", int'(int_out), 0);
        // R8: non-specific clears level 1, so level 1 may be raised again
        eoi_ns();
        check("R8 5 still blocked", int'(int_out), 0);
        pulse(8'h02);
        check("R8 level1 cleared", int'(int_out), 1);
        ack(8'hA9);
        eoi_ns();
        check("R8 2 remains", int'(int_out), 0);
        // R7: specific clears level 2, releasing level 5
        eoi_s(2);
        check("R7 release", int'(int_out), 1);
        ack(8'hAD);
        eoi_s(5);
        check("R7 empty", int'(int_out), 0);

        // R2: held line gives one request only
        irq_in[3] = 1'b1;
        @(negedge clk);
        check("R2 held raise", int'(int_out), 1);
        ack(8'hAB);
        eoi_s(3);
        check("R2 held no repeat", int'(int_out), 0);
        irq_in[3] = 1'b0;
        // R5: ignored acknowledge
        ack(8'hAB);
        check("R5 ignored ack", int'(int_out), 0);

        // R3: mask
        wr(2'd0, 8'h10);
        pulse(8'h10);
        check("R3 masked", int'(int_out), 0);
        wr(2'd0, 8'h00);
        check("R3 unmasked", int'(int_out), 1);
        ack(8'hAC);
        eoi_s(4);

        // R4: fixed order 0,3,6,7
        pulse(8'hC9);
        ack(8'hA8); eoi_s(0);
        ack(8'hAB); eoi_s(3);
        ack(8'hAE); eoi_s(6);
        ack(8'hAF); eoi_s(7);
        check("R4 drained", int'(int_out), 0);

        // R9: automatic end-of-interrupt
        wr(2'd2, 8'h02);
        pulse(8'h44);
        ack(8'hAA);
        check("R9 next served", int'(int_out), 1);
        ack(8'hAE);
        check("R9 drained", int'(int_out), 0);

        // R10: rotating priority
        wr(2'd2, 8'h01);
        pulse(8'h08);
        ack(8'hAB); eoi_s(3);
        pulse(8'h15);
        ack(8'hAC); eoi_ns();
        ack(8'hA8); eoi_ns();
        ack(8'hAA); eoi_ns();
        check("R10 drained", int'(int_out), 0);
        // R10 with automatic retirement: pointer at 2 -> 6, 7, 1
        wr(2'd2, 8'h03);
        pulse(8'hC2);
        ack(8'hAE);
        ack(8'hAF);
        ack(8'hA9);
        // R10: back to fixed order
        wr(2'd2, 8'h00);
        pulse(8'h21);
        ack(8'hA8); eoi_ns();
        ack(8'hAD); eoi_ns();
        check("R10 fixed drained", int'(int_out), 0);

        @(negedge clk);
        @(negedge clk);
        check("R5 queue empty", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule